// File: doc/BRIEF.md
# Global Clock Source Selector with Glitch-Free Gating

This block chooses which of six candidate clocks drives one global clock net, and gates that net on and off without producing runt pulses. The candidates are two dedicated clock pins, two PLL counter outputs, one dual-purpose pin and one signal coming from the fabric. Selection happens in two tiers. A parameter fixed at build time decides the source class: the dynamic group, the dual-purpose pin alone, or the fabric signal alone. When the dynamic group is chosen, a 2-bit run-time select picks one of its four clocks.

Each candidate in use passes through a gate cell. The cell captures its request on the falling edge of its own clock, so the gate opens and closes only while that clock is low. Inside the dynamic group, the gate cells are interlocked. On a select change the old clock is shut on its low phase before the new one opens on its own low phase. Gating happens at the net, not at the source, so a PLL feeding the block keeps running and stays locked while the net is off.

When the net feeds an external pin path, a parameter lengthens each gate cell to two falling-edge stages. A flag output reports whether the chosen class can serve as a PLL reference.

Top module: `gclk_source_ctrl`

## Requirements
- R1: With the dynamic class and the enable high, `gclk_out` follows the clock named by `clk_sel` once the handoff completes: code 0 gives `pin_clk0`, 1 gives `pin_clk1`, 2 gives `pll_clk0`, 3 gives `pll_clk1`.
- R2: With the dual-purpose class, `gclk_out` follows `dual_clk` while enabled, and `clk_sel` has no effect on it.
- R3: With the fabric class, `gclk_out` follows `fabric_clk` while enabled, and `clk_sel` has no effect on it.
- R4: While `clk_en` is low and the gate has closed, `gclk_out` stays constant low even though the sources keep toggling.
- R5: The enable is captured on the falling edge of the selected clock. A gate opens or closes only while that clock is low. A rise of `clk_en` during a high phase produces no output until the next rising edge after a falling edge. A drop of `clk_en` during a high phase does not shorten that pulse.
- R6: With `EXT_PIN_PATH` = 1, the enable passes through two falling-edge stages, which adds one extra period of the selected clock before the output starts.
- R7: A change of `clk_sel` is handed off glitch-free. At most one channel gate is open at any time, gates change only while their own clock is low, and no high pulse on `gclk_out` is shorter than a half period of a source. Rapid back-and-forth switching also meets these rules.
- R8: `ref_ok` is 1 for the dynamic class and 0 for the dual-purpose and fabric classes.
- R9: While `rst_n` is low, all gates are cleared and `gclk_out` is low. After release with `clk_en` high and `clk_sel` = 0, the output follows `pin_clk0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all gate stages |
| pin_clk0 | input | 1 | Dedicated clock pin, dynamic code 0 |
| pin_clk1 | input | 1 | Dedicated clock pin, dynamic code 1 |
| pll_clk0 | input | 1 | PLL counter output, dynamic code 2 |
| pll_clk1 | input | 1 | PLL counter output, dynamic code 3 |
| dual_clk | input | 1 | Dual-purpose pin, statically selectable only |
| fabric_clk | input | 1 | Fabric-driven signal, statically selectable only |
| clk_sel | input | 2 | Run-time choice inside the dynamic group |
| clk_en | input | 1 | Net enable, captured on falling clock edges |
| gclk_out | output | 1 | Gated global clock |
| ref_ok | output | 1 | High when the output may serve as a PLL reference |

## Verification
The bench raises and drops the enable in the middle of a high phase. A design that sampled on the rising edge, or that gated combinationally, would show a clipped pulse or an early edge at the sample points chosen there. The extended external path must start exactly one period later, so a missing or extra stage shifts the first pulse past a checked instant. Bursts of select changes a few nanoseconds apart try to open two channels at once. Any interlock that watched only the final stage, or any gate updated on the wrong edge, would leave a runt pulse that the pulse-width monitor counts. Toggling the select on the static-class units catches any path that lets the run-time select leak into them.

// File: rtl/gclk_src_pkg.sv
package gclk_src_pkg;

  typedef enum logic [1:0] {
    SRC_DYNAMIC = 2'd0,
    SRC_DUALPIN = 2'd1,
    SRC_FABRIC  = 2'd2
  } src_class_e;

  localparam int DYN_CH    = 4;
  localparam int SEL_W     = $clog2(DYN_CH);

  // number of falling-edge stages the enable crosses
  function automatic int gate_depth(bit ext_path);
    return ext_path ? 2 : 1;
  endfunction

  // one-hot request vector for a run-time select code
  function automatic logic [DYN_CH-1:0] sel_decode(logic [SEL_W-1:0] code);
    logic [DYN_CH-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  // only pins and PLL outputs may feed a PLL reference
  function automatic bit ref_capable(src_class_e cls);
    return cls == SRC_DYNAMIC;
  endfunction

endpackage

// File: rtl/gclk_gate_cell.sv
module gclk_gate_cell #(
  parameter int DEPTH = 1
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  input  logic blocked,
  output logic gate_on,
  output logic busy
);
  logic [DEPTH-1:0] stg;

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= want & ~blocked;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign gate_on = stg[DEPTH-1];
  assign busy    = |stg;
endmodule

// File: rtl/gclk_dyn_mux.sv
module gclk_dyn_mux
  import gclk_src_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic [DYN_CH-1:0] clk_vec,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic              out,
  output logic [DYN_CH-1:0] gate_vec
);
  logic [DYN_CH-1:0] want_vec;
  logic [DYN_CH-1:0] busy_vec;
  logic [DYN_CH-1:0] others_busy;

  assign want_vec = sel_decode(sel) & {DYN_CH{en}};

  for (genvar ch = 0; ch < DYN_CH; ch++) begin : g_ch
    // any stage of another channel in flight blocks this one
    assign others_busy[ch] = |(busy_vec & ~(DYN_CH'(1) << ch));

    gclk_gate_cell #(.DEPTH(DEPTH)) u_cell (
      .clk_src (clk_vec[ch]),
      .rst_n   (rst_n),
      .want    (want_vec[ch]),
      .blocked (others_busy[ch]),
      .gate_on (gate_vec[ch]),
      .busy    (busy_vec[ch])
    );
  end

  always_comb begin
    out = 1'b0;
    for (int i = 0; i < DYN_CH; i++) out = out | (clk_vec[i] & gate_vec[i]);
  end
endmodule

// File: rtl/gclk_source_ctrl.sv
module gclk_source_ctrl
  import gclk_src_pkg::*;
#(
  parameter src_class_e SRC_CLASS    = SRC_DYNAMIC,
  parameter bit         EXT_PIN_PATH = 1'b0
) (
  input  logic             rst_n,
  input  logic             pin_clk0,
  input  logic             pin_clk1,
  input  logic             pll_clk0,
  input  logic             pll_clk1,
  input  logic             dual_clk,
  input  logic             fabric_clk,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             clk_en,
  output logic             gclk_out,
  output logic             ref_ok
);
  localparam int DEPTH = gate_depth(EXT_PIN_PATH);

  // named internal events for the checker
  logic [DYN_CH-1:0] ch_clk;
  logic [DYN_CH-1:0] ch_gate;

  if (SRC_CLASS == SRC_DYNAMIC) begin : g_dyn
    logic unused_static;
    assign unused_static = &{1'b0, dual_clk, fabric_clk};
    assign ch_clk = {pll_clk1, pll_clk0, pin_clk1, pin_clk0};

    gclk_dyn_mux #(.DEPTH(DEPTH)) u_mux (
      .clk_vec  (ch_clk),
      .rst_n    (rst_n),
      .en       (clk_en),
      .sel      (clk_sel),
      .out      (gclk_out),
      .gate_vec (ch_gate)
    );
  end else begin : g_static
    logic unused_dyn;
    logic one_gate;
    logic one_busy;
    logic src_lvl;
    assign unused_dyn = &{1'b0, clk_sel, pin_clk0, pin_clk1, pll_clk0, pll_clk1, one_busy};
    assign src_lvl = (SRC_CLASS == SRC_DUALPIN) ? dual_clk : fabric_clk;
    assign ch_clk  = {{(DYN_CH-1){1'b0}}, src_lvl};
    assign ch_gate = {{(DYN_CH-1){1'b0}}, one_gate};

    gclk_gate_cell #(.DEPTH(DEPTH)) u_cell (
      .clk_src (src_lvl),
      .rst_n   (rst_n),
      .want    (clk_en),
      .blocked (1'b0),
      .gate_on (one_gate),
      .busy    (one_busy)
    );
    assign gclk_out = src_lvl & one_gate;
  end

  assign ref_ok = ref_capable(SRC_CLASS);
endmodule

// File: rtl/gclk_source_ctrl_chk.sv
module gclk_source_ctrl_chk
  import gclk_src_pkg::*;
(
  input logic              rst_n,
  input logic [5:0]        src_vec,
  input logic [DYN_CH-1:0] ch_clk,
  input logic [DYN_CH-1:0] ch_gate,
  input logic              gclk_out,
  input logic              ref_ok
);
  // R7: never two channels open together
  always @(ch_gate) begin
    if (rst_n === 1'b1)
      a_r7_single_gate: assert ($onehot0(ch_gate));
  end

  // R5: gates move only in the low phase of their own clock
  for (genvar i = 0; i < DYN_CH; i++) begin : g_edge
    always @(posedge ch_gate[i]) begin
      if (rst_n === 1'b1)
        a_r5_open_low: assert (ch_clk[i] === 1'b0);
    end
    always @(negedge ch_gate[i]) begin
      if (rst_n === 1'b1)
        a_r5_close_low: assert (ch_clk[i] === 1'b0);
    end
  end

  // R9: reset silences the net
  always @(gclk_out or rst_n) begin
    if (rst_n === 1'b0)
      a_r9_reset_quiet: assert (gclk_out !== 1'b1);
  end

  // R4: an output edge needs exactly one open gate
  always @(posedge gclk_out) begin
    if (rst_n === 1'b1)
      a_r4_needs_gate: assert ($countones(ch_gate) == 1);
  end

  // R8: reference-capable outputs come from pins or PLLs only
  always @(posedge gclk_out) begin
    if (rst_n === 1'b1) begin
      if (ref_ok)
        a_r8_ref_from_group: assert (|src_vec[3:0]);
      else
        a_r8_static_source: assert (src_vec[4] | src_vec[5]);
    end
  end
endmodule

bind gclk_source_ctrl gclk_source_ctrl_chk u_chk (
  .rst_n    (rst_n),
  .src_vec  ({fabric_clk, dual_clk, pll_clk1, pll_clk0, pin_clk1, pin_clk0}),
  .ch_clk   (ch_clk),
  .ch_gate  (ch_gate),
  .gclk_out (gclk_out),
  .ref_ok   (ref_ok)
);

// File: tb/tb_gclk_source_ctrl.sv
`timescale 1ns/100ps
module tb_gclk_source_ctrl;
  import gclk_src_pkg::*;

  logic clk = 1'b0;        // pin_clk0, 125 MHz
  logic pin1 = 1'b0, pll0 = 1'b0, pll1 = 1'b0, dclk = 1'b0, fclk = 1'b0;
  always #4  clk  = ~clk;
  always #6  pin1 = ~pin1;
  always #5  pll0 = ~pll0;
  always #10 pll1 = ~pll1;
  always #7  dclk = ~dclk;
  always #9  fclk = ~fclk;

  logic       rst_n = 1'b0;
  logic       en_a = 1'b1, en_s = 1'b1;
  logic [1:0] sel_a = 2'd0, sel_s = 2'd0;
  logic out_d, out_x, out_p, out_f;
  logic ok_d, ok_x, ok_p, ok_f;

  gclk_source_ctrl #(.SRC_CLASS(SRC_DYNAMIC), .EXT_PIN_PATH(1'b0)) dut (
    .rst_n(rst_n), .pin_clk0(clk), .pin_clk1(pin1), .pll_clk0(pll0), .pll_clk1(pll1),
    .dual_clk(dclk), .fabric_clk(fclk), .clk_sel(sel_a), .clk_en(en_a),
    .gclk_out(out_d), .ref_ok(ok_d));
  gclk_source_ctrl #(.SRC_CLASS(SRC_DYNAMIC), .EXT_PIN_PATH(1'b1)) dut_ext (
    .rst_n(rst_n), .pin_clk0(clk), .pin_clk1(pin1), .pll_clk0(pll0), .pll_clk1(pll1),
    .dual_clk(dclk), .fabric_clk(fclk), .clk_sel(sel_a), .clk_en(en_a),
    .gclk_out(out_x), .ref_ok(ok_x));
  gclk_source_ctrl #(.SRC_CLASS(SRC_DUALPIN), .EXT_PIN_PATH(1'b0)) dut_dual (
    .rst_n(rst_n), .pin_clk0(clk), .pin_clk1(pin1), .pll_clk0(pll0), .pll_clk1(pll1),
    .dual_clk(dclk), .fabric_clk(fclk), .clk_sel(sel_s), .clk_en(en_s),
    .gclk_out(out_p), .ref_ok(ok_p));
  gclk_source_ctrl #(.SRC_CLASS(SRC_FABRIC), .EXT_PIN_PATH(1'b0)) dut_fab (
    .rst_n(rst_n), .pin_clk0(clk), .pin_clk1(pin1), .pll_clk0(pll0), .pll_clk1(pll1),
    .dual_clk(dclk), .fabric_clk(fclk), .clk_sel(sel_s), .clk_en(en_s),
    .gclk_out(out_f), .ref_ok(ok_f));

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    unit;
    int    src;
    bit    on;
    int    n;
    string req;
  } exp_t;
  exp_t q[$];
  bit   busy = 1'b0;

  function automatic logic src_lvl(int s);
    case (s)
      0: return clk;
      1: return pin1;
      2: return pll0;
      3: return pll1;
      4: return dclk;
      default: return fclk;
    endcase
  endfunction

  function automatic logic unit_out(int u);
    case (u)
      0: return out_d;
      1: return out_x;
      2: return out_p;
      default: return out_f;
    endcase
  endfunction

  task automatic check1(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $realtime, act, expv);
    end
  endtask

  // driver: push an expectation window and wait until the monitor has consumed it
  task automatic expect_window(int unit, int src, bit on, int n, string req);
    exp_t it;
    it.unit = unit; it.src = src; it.on = on; it.n = n; it.req = req;
    q.push_back(it);
    wait (q.size() == 0 && !busy);
  endtask

  // monitor: samples half a nanosecond away from any clock edge
  initial begin
    forever begin
      exp_t it;
      int   bad;
      logic a, e;
      wait (q.size() > 0);
      busy = 1'b1;
      it = q.pop_front();
      bad = 0; a = 1'b0; e = 1'b0;
      for (int k = 0; k < it.n; k++) begin
        #1;
        if (bad == 0) begin
          a = unit_out(it.unit);
          e = it.on ? src_lvl(it.src) : 1'b0;
          if (a !== e) bad = 1;
        end
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s unit %0d at %0t: got %b expected %b", it.req, it.unit, $realtime, a, e);
      end
      busy = 1'b0;
    end
  end

  // pulse-width monitors for R7
  int   short_d = 0, short_x = 0;
  realtime rise_d = 0.0, rise_x = 0.0;
  always @(posedge out_d) rise_d = $realtime;
  always @(negedge out_d) if (rst_n && ($realtime - rise_d) < 3.9) short_d++;
  always @(posedge out_x) rise_x = $realtime;
  always @(negedge out_x) if (rst_n && ($realtime - rise_x) < 3.9) short_x++;

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #0.5;
    #25;
    // R9: outputs low during reset while sources run and enables are high
    expect_window(0, 0, 1'b0, 15, "R9 reset dyn");
    expect_window(1, 0, 1'b0, 15, "R9 reset ext");
    expect_window(2, 4, 1'b0, 15, "R9 reset dual");
    expect_window(3, 5, 1'b0, 15, "R9 reset fabric");
    rst_n = 1'b1;
    #100;
    expect_window(0, 0, 1'b1, 40, "R9 select 0 after reset");
    expect_window(1, 0, 1'b1, 40, "R1 ext code 0");

    // R8: reference flag per class
    check1("R8 dynamic ref", ok_d, 1'b1);
    check1("R8 ext ref", ok_x, 1'b1);
    check1("R8 dual no ref", ok_p, 1'b0);
    check1("R8 fabric no ref", ok_f, 1'b0);

    // R1: each run-time code
    for (int s = 1; s < 4; s++) begin
      sel_a = 2'(s);
      #100;
      expect_window(0, s, 1'b1, 40, "R1 code map");
    end
    #100;
    expect_window(1, 3, 1'b1, 40, "R1 ext code 3");

    // R2 / R3: run-time select has no effect on static classes
    expect_window(2, 4, 1'b1, 40, "R2 dual sel 0");
    expect_window(3, 5, 1'b1, 40, "R3 fabric sel 0");
    sel_s = 2'd3;
    #20;
    expect_window(2, 4, 1'b1, 40, "R2 dual sel 3");
    expect_window(3, 5, 1'b1, 40, "R3 fabric sel 3");
    sel_s = 2'd2;
    #20;
    expect_window(2, 4, 1'b1, 40, "R2 dual sel 2");

    // R4: disable holds the net low
    en_a = 1'b0;
    #100;
    expect_window(0, 3, 1'b0, 60, "R4 dyn off");
    expect_window(1, 3, 1'b0, 60, "R4 ext off");
    en_s = 1'b0;
    #40;
    expect_window(2, 4, 1'b0, 40, "R4 dual off");
    expect_window(3, 5, 1'b0, 40, "R4 fabric off");

    // R5 / R6: enable raised mid high phase of pin_clk0
    sel_a = 2'd0;
    #60;
    @(posedge clk);
    #1.5;                       // phase 5.5 of an 8 ns period, clock high
    en_a = 1'b1;
    #0.5;
    check1("R5 no output before falling edge", out_d, 1'b0);
    #6.5;                       // phase 12.5: first full high after capture
    check1("R5 output starts after falling edge", out_d, 1'b1);
    check1("R6 ext still closed", out_x, 1'b0);
    #8;                         // phase 20.5
    check1("R6 ext opens one period later", out_x, 1'b1);
    #40;
    @(posedge clk);
    #1.5;
    en_a = 1'b0;
    #0.5;
    check1("R5 pulse not clipped by disable", out_d, 1'b1);
    #6.5;
    check1("R5 closed after falling edge", out_d, 1'b0);

    // R7: glitch-free handoff under rapid switching
    en_a = 1'b1;
    #100;
    for (int k = 0; k < 40; k++) begin
      sel_a = 2'(k % 4);
      #(3 + (k % 5));
    end
    sel_a = 2'd2;
    #150;
    expect_window(0, 2, 1'b1, 40, "R7 settles on new clock");
    expect_window(1, 2, 1'b1, 40, "R7 ext settles on new clock");
    sel_a = 2'd1;
    #3;
    sel_a = 2'd3;
    #150;
    expect_window(0, 3, 1'b1, 40, "R7 second hop");
    check1("R7 no runt pulse dyn", short_d == 0, 1'b1);
    check1("R7 no runt pulse ext", short_x == 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule